// File: doc/BRIEF.md
# Readout Link Frame Builder

This block turns the word stream of one detector readout into a framed stream for a serial link. A readout begins with a one-cycle start strobe. The block then accepts payload words, which alternate between channel identifier and sample value, until one is flagged as last. It puts a header word in front of the payload and a trailer word after it. It presents one word per clock to an external serializer. When no frame is running, a fixed idle word fills the link.

For link testing, a 64-entry pattern store is written over a simple write port. A test command sends the stored words as the payload of a frame in place of detector data. A test command is accepted only between frames. A command that arrives while a frame is open is refused and reported with a one-cycle pulse, and it is not queued.

Top module: `lnk_frame_builder`

## Requirements
- R1: While reset is asserted, `out_valid` is 0, `out_kind` is 0, `out_word` equals the idle word (default 0x5A5A) and `tst_refused` is 0.
- R2: In every cycle that carries no frame word, `out_valid` is 0, `out_kind` is 0 (idle) and `out_word` is the idle word. This includes gaps inside an event payload.
- R3: `evt_start`, sampled while no frame is open, produces a header one cycle later with `out_kind`=1. Bits 15:12 of the header are 0xA, bit 11 is 0, and bits 10:0 hold a frame counter. The counter starts at 0, rises by one after every trailer (event or test) and wraps from 2047 to 0.
- R4: Each event word sampled with `evt_word_valid` during the payload appears unchanged one cycle later with `out_valid`=1. Payload kinds alternate 2 (channel identifier) and 3 (data), starting with 2 in every frame.
- R5: The cycle after the word flagged with `evt_last` carries the trailer: `out_kind`=4, bits 15:12 equal to 0xE, and bits 11:0 equal to the number of payload words in the frame (modulo 4096).
- R6: `evt_word_valid` has no effect outside an event payload. `evt_start` has no effect while a frame (payload or trailer) is open.
- R7: A write with `cfg_we` stores `cfg_wdata` at pattern entry `cfg_addr`. The stored value is what a later test frame sends for that entry.
- R8: `tst_go`, sampled while no frame is open and without `evt_start`, produces a header with bit 11 set. This is followed by the 64 stored entries in address order 0 to 63 on consecutive cycles (kinds alternating 2/3), then a trailer with count 64.
- R9: `tst_go` sampled while a frame is open, or in the same cycle as an accepted `evt_start`, is refused. `tst_refused` is 1 for exactly the following cycle, no test frame starts, and the running or starting event frame continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_start | input | 1 | Start of one readout |
| evt_word_valid | input | 1 | Payload word present this cycle |
| evt_word | input | 16 | Payload word (identifier or data) |
| evt_last | input | 1 | Marks the final payload word |
| tst_go | input | 1 | Request to send the stored test pattern |
| cfg_we | input | 1 | Pattern store write enable |
| cfg_addr | input | 6 | Pattern store entry |
| cfg_wdata | input | 16 | Pattern store write data |
| out_valid | output | 1 | Frame word on `out_word` |
| out_kind | output | 3 | 0 idle, 1 header, 2 identifier, 3 data, 4 trailer |
| out_word | output | 16 | Word to the serializer |
| tst_refused | output | 1 | Test command was rejected |

## Verification
A corrupted frame counter shows as a header value that does not step by one from the previous header. This is visible at the next frame boundary. A wrong payload counter or parity bit shows as the same identifier/data kind twice in a row, or as a trailer count that differs from the number of words seen. Both appear within one frame. A stuck state register shows up within a cycle or two: the link stays on idle fill after a start, or emits words with no header before them. The bench compares every output cycle against its own frame model, so any of these faults is reported in the cycle where it first appears.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
    localparam int MARK_W = 4;
    localparam logic [MARK_W-1:0] HEAD_MARK  = 4'hA;
    localparam logic [MARK_W-1:0] TRAIL_MARK = 4'hE;

    typedef enum logic [2:0] {
        K_IDLE  = 3'd0,
        K_HEAD  = 3'd1,
        K_CHID  = 3'd2,
        K_DATA  = 3'd3,
        K_TRAIL = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVT,
        S_TST,
        S_TRL
    } state_e;
endpackage

// File: rtl/lfb_pattern_ram.sv
module lfb_pattern_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // write lands at the edge; a read in the same cycle still sees the old entry
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lfb_word_fmt.sv
module lfb_word_fmt
    import lfb_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = W - MARK_W - 1,
    parameter int NW = W - MARK_W
) (
    input  logic          hdr_test,
    input  logic [CW-1:0] frame_cnt,
    input  logic [NW-1:0] pay_cnt,
    output logic [W-1:0]  head_word,
    output logic [W-1:0]  trail_word
);
    assign head_word  = {HEAD_MARK, hdr_test, frame_cnt};
    assign trail_word = {TRAIL_MARK, pay_cnt};
endmodule

// File: rtl/lfb_frame_ctl.sv
module lfb_frame_ctl
    import lfb_pkg::*;
#(
    parameter int          W         = 16,
    parameter int          DEPTH     = 64,
    parameter int          AW        = $clog2(DEPTH),
    parameter int          CW        = W - MARK_W - 1,
    parameter int          NW        = W - MARK_W,
    parameter logic [W-1:0] IDLE_WORD = 16'h5A5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_start,
    input  logic          evt_word_valid,
    input  logic [W-1:0]  evt_word,
    input  logic          evt_last,
    input  logic          tst_go,
    input  logic [W-1:0]  ram_rdata,
    input  logic [W-1:0]  head_word,
    input  logic [W-1:0]  trail_word,
    output logic          hdr_test,
    output logic [CW-1:0] frame_cnt,
    output logic [NW-1:0] pay_cnt,
    output logic [AW-1:0] ram_raddr,
    output logic          out_valid,
    output logic [2:0]    out_kind,
    output logic [W-1:0]  out_word,
    output logic          tst_refused
);
    localparam logic [NW-1:0] LAST_IDX = NW'(DEPTH - 1);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] fcnt;
        logic [NW-1:0] pcnt;
        logic          vld;
        kind_e         kind;
        logic [W-1:0]  word;
        logic          refused;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.vld     = 1'b0;
        r_d.kind    = K_IDLE;
        r_d.word    = IDLE_WORD;
        r_d.refused = 1'b0;
        hdr_test    = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (evt_start) begin
                    r_d.st      = S_EVT;
                    r_d.pcnt    = '0;
                    r_d.vld     = 1'b1;
                    r_d.kind    = K_HEAD;
                    r_d.word    = head_word;
                    r_d.refused = tst_go;
                end else if (tst_go) begin
                    hdr_test = 1'b1;
                    r_d.st   = S_TST;
                    r_d.pcnt = '0;
                    r_d.vld  = 1'b1;
                    r_d.kind = K_HEAD;
                    r_d.word = head_word;
                end
            end
            S_EVT: begin
                r_d.refused = tst_go;
                if (evt_word_valid) begin
                    r_d.vld  = 1'b1;
                    r_d.kind = r_q.pcnt[0] ? K_DATA : K_CHID;
                    r_d.word = evt_word;
                    r_d.pcnt = r_q.pcnt + NW'(1);
                    if (evt_last) begin
                        r_d.st = S_TRL;
                    end
                end
            end
            S_TST: begin
                r_d.refused = tst_go;
                r_d.vld     = 1'b1;
                r_d.kind    = r_q.pcnt[0] ? K_DATA : K_CHID;
                r_d.word    = ram_rdata;
                r_d.pcnt    = r_q.pcnt + NW'(1);
                if (r_q.pcnt == LAST_IDX) begin
                    r_d.st = S_TRL;
                end
            end
            S_TRL: begin
                r_d.refused = tst_go;
                r_d.vld     = 1'b1;
                r_d.kind    = K_TRAIL;
                r_d.word    = trail_word;
                r_d.fcnt    = r_q.fcnt + CW'(1);
                r_d.st      = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, fcnt: '0, pcnt: '0, vld: 1'b0,
                     kind: K_IDLE, word: IDLE_WORD, refused: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_cnt   = r_q.fcnt;
    assign pay_cnt     = r_q.pcnt;
    assign ram_raddr   = r_q.pcnt[AW-1:0];
    assign out_valid   = r_q.vld;
    assign out_kind    = r_q.kind;
    assign out_word    = r_q.word;
    assign tst_refused = r_q.refused;
endmodule

// File: rtl/lnk_frame_builder.sv
module lnk_frame_builder
    import lfb_pkg::*;
#(
    parameter int           W         = 16,
    parameter int           DEPTH     = 64,
    parameter logic [W-1:0] IDLE_WORD = 16'h5A5A,
    parameter int           AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_start,
    input  logic          evt_word_valid,
    input  logic [W-1:0]  evt_word,
    input  logic          evt_last,
    input  logic          tst_go,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    output logic          out_valid,
    output logic [2:0]    out_kind,
    output logic [W-1:0]  out_word,
    output logic          tst_refused
);
    localparam int CW = W - MARK_W - 1;
    localparam int NW = W - MARK_W;

    logic [W-1:0]  ram_rdata;
    logic [AW-1:0] ram_raddr;
    logic [W-1:0]  head_word;
    logic [W-1:0]  trail_word;
    logic          hdr_test;
    logic [CW-1:0] frame_cnt;
    logic [NW-1:0] pay_cnt;

    lfb_pattern_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    lfb_word_fmt #(.W(W), .CW(CW), .NW(NW)) u_fmt (
        .hdr_test   (hdr_test),
        .frame_cnt  (frame_cnt),
        .pay_cnt    (pay_cnt),
        .head_word  (head_word),
        .trail_word (trail_word)
    );

    lfb_frame_ctl #(
        .W(W), .DEPTH(DEPTH), .AW(AW), .CW(CW), .NW(NW), .IDLE_WORD(IDLE_WORD)
    ) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_start      (evt_start),
        .evt_word_valid (evt_word_valid),
        .evt_word       (evt_word),
        .evt_last       (evt_last),
        .tst_go         (tst_go),
        .ram_rdata      (ram_rdata),
        .head_word      (head_word),
        .trail_word     (trail_word),
        .hdr_test       (hdr_test),
        .frame_cnt      (frame_cnt),
        .pay_cnt        (pay_cnt),
        .ram_raddr      (ram_raddr),
        .out_valid      (out_valid),
        .out_kind       (out_kind),
        .out_word       (out_word),
        .tst_refused    (tst_refused)
    );
endmodule

// File: rtl/lnk_frame_builder_chk.sv
module lnk_frame_builder_chk
    import lfb_pkg::*;
#(
    parameter int           W         = 16,
    parameter int           DEPTH     = 64,
    parameter logic [W-1:0] IDLE_WORD = 16'h5A5A
) (
    input logic         clk,
    input logic         rst_n,
    input logic         out_valid,
    input logic [2:0]   out_kind,
    input logic [W-1:0] out_word,
    input logic         tst_refused
);
    localparam int CW = W - MARK_W - 1;
    localparam int NW = W - MARK_W;

    logic [CW-1:0] last_hdr_q;
    logic          seen_hdr_q;
    logic [NW-1:0] seen_pay_q;
    logic          last_chid_q;
    logic          test_frame_q;
    logic [CW-1:0] next_hdr;
    logic          is_pay;

    assign next_hdr = last_hdr_q + CW'(1);
    assign is_pay   = (out_kind == K_CHID) || (out_kind == K_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_hdr_q   <= '0;
            seen_hdr_q   <= 1'b0;
            seen_pay_q   <= '0;
            last_chid_q  <= 1'b0;
            test_frame_q <= 1'b0;
        end else if (out_kind == K_HEAD) begin
            last_hdr_q   <= out_word[CW-1:0];
            seen_hdr_q   <= 1'b1;
            seen_pay_q   <= '0;
            last_chid_q  <= 1'b0;
            test_frame_q <= out_word[CW];
        end else if (is_pay) begin
            seen_pay_q  <= seen_pay_q + NW'(1);
            last_chid_q <= (out_kind == K_CHID);
        end
    end

    a_r2_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_kind == K_IDLE && out_word == IDLE_WORD));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == K_HEAD && seen_hdr_q) |-> (out_word[CW-1:0] == next_hdr));

    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        is_pay |-> ((out_kind == K_DATA) == last_chid_q));

    a_r5_trailer_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == K_TRAIL) |->
            (out_word[W-1:NW] == TRAIL_MARK && out_word[NW-1:0] == seen_pay_q));

    a_r8_test_length: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == K_TRAIL && test_frame_q) |-> (out_word[NW-1:0] == NW'(DEPTH)));

    a_r9_no_test_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        tst_refused |-> !(out_kind == K_HEAD && out_word[CW]));
endmodule

bind lnk_frame_builder lnk_frame_builder_chk #(
    .W(W), .DEPTH(DEPTH), .IDLE_WORD(IDLE_WORD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid   (out_valid),
    .out_kind    (out_kind),
    .out_word    (out_word),
    .tst_refused (tst_refused)
);

// File: tb/sim_lnk_frame_builder.sv
`timescale 1ns/1ps
module sim_lnk_frame_builder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_start = 1'b0, evt_word_valid = 1'b0, evt_last = 1'b0;
    logic [15:0] evt_word = '0;
    logic        tst_go = 1'b0, cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid, tst_refused;
    logic [2:0]  out_kind;
    logic [15:0] out_word;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench frame model
    int          ms = 0;
    int          mf = 0;
    int          mp = 0;
    bit          mtest = 1'b0;
    logic [15:0] pat [64];

    always #2 clk = ~clk;

    lnk_frame_builder u0 (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_word_valid(evt_word_valid),
        .evt_word(evt_word), .evt_last(evt_last), .tst_go(tst_go), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_kind(out_kind), .out_word(out_word), .tst_refused(tst_refused)
    );

    task automatic check(input string rq, input logic [20:0] act, input logic [20:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got v/k/w/r=%h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic es, input logic tg, input logic wv, input logic [15:0] wd,
                       input logic wl, input logic we, input logic [5:0] wa,
                       input logic [15:0] wdat, input string rq);
        logic        ev, er;
        logic [2:0]  ek;
        logic [15:0] ew;
        string       lab;
        @(negedge clk);
        evt_start = es; tst_go = tg; evt_word_valid = wv; evt_word = wd; evt_last = wl;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wdat;
        ev = 1'b0; ek = 3'd0; ew = 16'h5A5A; er = 1'b0; lab = "R2";
        case (ms)
            0: begin
                if (es) begin
                    ev = 1; ek = 1; ew = {4'hA, 1'b0, 11'(mf)}; er = tg;
                    ms = 1; mp = 0; mtest = 0; lab = tg ? "R9" : "R3";
                end else if (tg) begin
                    ev = 1; ek = 1; ew = {4'hA, 1'b1, 11'(mf)};
                    ms = 2; mp = 0; mtest = 1; lab = "R8";
                end
            end
            1: begin
                er = tg;
                if (wv) begin
                    ev = 1; ek = mp[0] ? 3'd3 : 3'd2; ew = wd; mp++; lab = "R4";
                    if (wl) ms = 3;
                end
                if (tg) lab = "R9";
            end
            2: begin
                er = tg; ev = 1; ek = mp[0] ? 3'd3 : 3'd2; ew = pat[mp]; lab = tg ? "R9" : "R8";
                if (mp == 63) ms = 3;
                mp++;
            end
            default: begin
                er = tg; ev = 1; ek = 3'd4; ew = {4'hE, 12'(mp)};
                lab = tg ? "R9" : (mtest ? "R8" : "R5");
                mf = (mf + 1) & 2047; ms = 0;
            end
        endcase
        if (we) pat[wa] = wdat;
        if (rq != "") lab = rq;
        @(posedge clk);
        #1;
        check(lab, {out_valid, out_kind, out_word, tst_refused}, {ev, ek, ew, er});
    endtask

    task automatic idle(input int n, input string rq);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {out_valid, out_kind, out_word, tst_refused}, {1'b0, 3'd0, 16'h5A5A, 1'b0});
        rst_n = 1'b1;
        // R6: stray event words in idle
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 16'h1111 * 16'(i + 1), 0, 0, 0, 0, "R6");
        // event frame with a stall and a stray start
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 1, 16'h0101, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 16'hDEAD, 0, 0, 0, 0, "R2");
        cyc(1, 0, 1, 16'h0ABC, 0, 0, 0, 0, "R6");
        cyc(0, 1, 1, 16'h0102, 0, 0, 0, 0, "R9");
        cyc(0, 0, 1, 16'h0D02, 1, 0, 0, 0, "R4");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R5");
        idle(2, "R2");
        // R7: load the pattern store
        for (int i = 0; i < 64; i++) cyc(0, 0, 0, 0, 0, 1, 6'(i), 16'($urandom), "R7");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, "R8");
        for (int i = 0; i < 65; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R7");
        idle(1, "R2");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, "");
        for (int i = 0; i < 65; i++) cyc(0, i == 10, 1, 0, 0, 0, 0, 0, "");
        // R9: start and test together
        cyc(1, 1, 0, 0, 0, 0, 0, 0, "R9");
        cyc(0, 0, 1, 16'h0007, 1, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R3: frame counter wrap
        for (int f = 0; f < 2050; f++) begin
            cyc(1, 0, 0, 0, 0, 0, 0, 0, "R3");
            cyc(0, 0, 1, 16'(f), 1, 0, 0, 0, "R4");
            cyc(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        end
        // constrained random traffic
        for (int i = 0; i < 5000; i++) begin
            cyc(($urandom % 8) == 0, ($urandom % 40) == 0, ($urandom % 3) != 0,
                16'($urandom), ($urandom % 6) == 0, ($urandom % 10) == 0,
                6'($urandom), 16'($urandom), "");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule